// File: doc/BRIEF.md
# Coalescing Interrupt Status Controller

This block collects hardware event pulses into sticky cause bits of a 32-bit status word. It drives a single host interrupt line from the causes that the host has enabled. To keep the host from being interrupted once per event, a programmable hold-off timer, counted in 32 µs units, delays the line after the first enabled cause appears. Any further causes that arrive while the timer runs are reported by the same interrupt. A dedicated high-priority receive input does not wait for the timer. A periodic receive cause can also be generated on its own programmable period.

The host reaches three word registers through a simple read/write port. Word 0 is the cause register, cleared by writing 1. Word 1 is the enable mask. Word 2 holds the timing fields. A microsecond tick comes from a clock prescaler (`CLK_PER_US` cycles per microsecond), and each timing unit is `US_PER_UNIT` (32) microseconds, so one unit lasts U = 32 × `CLK_PER_US` cycles.

The sequencer has three states. IDLE means no enabled cause is pending. HOLD means the hold-off timer is counting. FIRE means the line is raised. Its transitions are:
- start_hold: IDLE to HOLD, when a cause is pending and the hold-off value is nonzero.
- fire_now: IDLE to FIRE, when the hold-off value is zero or an urgent cause is present.
- expire: HOLD to FIRE, on the last unit tick.
- urgent: HOLD to FIRE, when the bypass cause arrives.
- rearm_hold: HOLD to IDLE, when all enabled causes are cleared.
- rearm_fire: FIRE to IDLE, when all enabled causes are cleared.

Top module: `irq_coalesce_ctrl`

## Requirements
- R1: After reset, the cause and enable registers are 0, the timing register reads 0x0000_0040 (hold-off 0x40, periodic 0), and `irq_out` is 0.
- R2: A 1 on any bit of `hw_event` in a cycle sets the matching cause bit at that clock edge, and the bit stays set until the host clears it.
- R3: A write to word 0 clears every cause bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When a hardware set and a host clear of the same cause bit occur in the same cycle, the bit ends up set.
- R5: Causes whose enable bit is 0 never raise `irq_out`. `irq_out` falls in the cycle after the edge where the last enabled cause is cleared. Enabling an already pending cause with hold-off 0 raises `irq_out` one cycle after the enable write.
- R6: With hold-off value N > 0, `irq_out` rises exactly N×U+1 cycles after the edge that captures the first enabled cause, and never without an enabled cause pending in the cycle before.
- R7: With hold-off value 0, `irq_out` rises one cycle after the capturing edge.
- R8: A pulse on `hipri_rx` sets cause bit 31. If bit 31 is enabled, `irq_out` rises one cycle later, even while the hold-off timer is counting.
- R9: Clearing all enabled causes, even partway through the hold-off, returns the timer to idle, so the next cause waits the full N×U+1 cycles.
- R10: Timing bits [15:8] = P > 0 set cause bit 28 every P×U cycles, counted from the edge that wrote the timing register. P = 0 stops these sets.
- R11: Read data is combinational from `reg_addr`. Address 0 reads causes, 1 the enable mask, 2 {16'b0, periodic, hold-off}, and 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_event | input | 32 | Per-cause event pulses |
| hipri_rx | input | 1 | High-priority receive event (cause 31, bypasses hold-off) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 1 | Host interrupt line |

## Verification
The assertions assume a single word address per cycle. The write-one-to-clear check assumes that no hardware event, urgent pulse or periodic set lands in the same cycle as the clear. For that reason it excludes bit 28 and fires only when `hw_event` and `hipri_rx` are quiet. The bench drives every input at the falling edge and holds events for exactly one cycle. It shrinks the prescaler to 2 cycles per microsecond so that each unit is 64 cycles, which lets the exact rise cycle of the line be checked.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        ADDR_CAUSE  = 2'd0,
        ADDR_ENABLE = 2'd1,
        ADDR_TIMING = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_FIRE = 2'd2
    } seq_state_e;

    localparam int CAUSE_W        = 32;
    localparam int TIMER_W        = 8;
    localparam int BIT_URGENT_RX  = 31;
    localparam int BIT_PERIODIC   = 28;
    localparam logic [TIMER_W-1:0] HOLDOFF_RESET = 8'h40;

endpackage

// File: rtl/irqc_timebase.sv
module irqc_timebase #(
    parameter int CLK_PER_US  = 250,
    parameter int US_PER_UNIT = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic unit_tick
);
    localparam int US_W   = $clog2(CLK_PER_US + 1);
    localparam int UNIT_W = $clog2(US_PER_UNIT + 1);

    logic [US_W-1:0]   us_cnt;
    logic [UNIT_W-1:0] unit_cnt;
    logic              us_end;

    assign us_end    = (us_cnt == US_W'(CLK_PER_US - 1));
    assign unit_tick = us_end && (unit_cnt == UNIT_W'(US_PER_UNIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            us_cnt   <= '0;
            unit_cnt <= '0;
        end else if (us_end) begin
            us_cnt <= '0;
            if (unit_tick) unit_cnt <= '0;
            else           unit_cnt <= unit_cnt + 1'b1;
        end else begin
            us_cnt <= us_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CAUSE_W-1:0] hw_event,
    input  logic               hipri_rx,
    input  logic               per_set,
    input  logic               reg_wr,
    input  logic [1:0]         reg_addr,
    input  logic [CAUSE_W-1:0] reg_wdata,
    output logic [CAUSE_W-1:0] cause_q,
    output logic [CAUSE_W-1:0] enable_q,
    output logic [TIMER_W-1:0] holdoff_q,
    output logic [TIMER_W-1:0] period_q,
    output logic               urgent_q,
    output logic               timing_wr,
    output logic [CAUSE_W-1:0] reg_rdata
);
    logic [CAUSE_W-1:0] set_vec;
    logic [CAUSE_W-1:0] clr_vec;
    logic [CAUSE_W-1:0] cause_d;

    assign timing_wr = reg_wr && (reg_addr == ADDR_TIMING);

    always_comb begin
        set_vec = hw_event;
        set_vec[BIT_URGENT_RX] = hw_event[BIT_URGENT_RX] | hipri_rx;
        set_vec[BIT_PERIODIC]  = hw_event[BIT_PERIODIC] | per_set;
        clr_vec = (reg_wr && reg_addr == ADDR_CAUSE) ? reg_wdata : '0;
        cause_d = (cause_q & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause_q   <= '0;
            enable_q  <= '0;
            holdoff_q <= HOLDOFF_RESET;
            period_q  <= '0;
            urgent_q  <= 1'b0;
        end else begin
            cause_q  <= cause_d;
            urgent_q <= hipri_rx | (urgent_q & cause_d[BIT_URGENT_RX]);
            if (reg_wr && reg_addr == ADDR_ENABLE) enable_q <= reg_wdata;
            if (timing_wr) begin
                holdoff_q <= reg_wdata[TIMER_W-1:0];
                period_q  <= reg_wdata[2*TIMER_W-1:TIMER_W];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_CAUSE:  reg_rdata = cause_q;
            ADDR_ENABLE: reg_rdata = enable_q;
            ADDR_TIMING: reg_rdata = {{(CAUSE_W-2*TIMER_W){1'b0}}, period_q, holdoff_q};
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_periodic.sv
module irqc_periodic
    import irqc_pkg::*;
#(
    parameter int CLK_PER_US  = 250,
    parameter int US_PER_UNIT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [TIMER_W-1:0] period,
    output logic               per_set
);
    logic               tick;
    logic               off;
    logic [TIMER_W-1:0] unit_cnt;

    assign off = (period == '0);

    irqc_timebase #(.CLK_PER_US(CLK_PER_US), .US_PER_UNIT(US_PER_UNIT)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart || off),
        .unit_tick (tick)
    );

    assign per_set = tick && !off && !restart && (unit_cnt == period - 1'b1);

    always_ff @(posedge clk) begin
        if (!rst_n || restart || off)        unit_cnt <= '0;
        else if (per_set)                    unit_cnt <= '0;
        else if (tick)                       unit_cnt <= unit_cnt + 1'b1;
    end
endmodule

// File: rtl/irqc_seq.sv
module irqc_seq
    import irqc_pkg::*;
#(
    parameter int CLK_PER_US  = 250,
    parameter int US_PER_UNIT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pending,
    input  logic               bypass,
    input  logic [TIMER_W-1:0] holdoff,
    output logic               irq
);
    seq_state_e         state_q, state_d;
    logic [TIMER_W-1:0] units_left;
    logic               tick;

    irqc_timebase #(.CLK_PER_US(CLK_PER_US), .US_PER_UNIT(US_PER_UNIT)) u_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (state_q != ST_HOLD),
        .unit_tick (tick)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pending) state_d = (bypass || holdoff == '0) ? ST_FIRE : ST_HOLD;
            ST_HOLD: begin
                if (!pending)                          state_d = ST_IDLE;
                else if (bypass)                       state_d = ST_FIRE;
                else if (tick && units_left == 8'd1)   state_d = ST_FIRE;
            end
            ST_FIRE: if (!pending) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                        units_left <= '0;
        else if (state_q == ST_IDLE)       units_left <= holdoff;
        else if (state_q == ST_HOLD && tick) units_left <= units_left - 1'b1;
    end

    always_comb begin
        irq = (state_q == ST_FIRE) && pending;
    end
endmodule

// File: rtl/irq_coalesce_ctrl.sv
module irq_coalesce_ctrl
    import irqc_pkg::*;
#(
    parameter int CLK_PER_US  = 250,
    parameter int US_PER_UNIT = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] hw_event,
    input  logic        hipri_rx,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_out
);
    logic [CAUSE_W-1:0] cause_q;
    logic [CAUSE_W-1:0] enable_q;
    logic [TIMER_W-1:0] holdoff_q;
    logic [TIMER_W-1:0] period_q;
    logic               urgent_q;
    logic               timing_wr;
    logic               per_set;
    logic               pending;
    logic               bypass;

    irqc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_event  (hw_event),
        .hipri_rx  (hipri_rx),
        .per_set   (per_set),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cause_q   (cause_q),
        .enable_q  (enable_q),
        .holdoff_q (holdoff_q),
        .period_q  (period_q),
        .urgent_q  (urgent_q),
        .timing_wr (timing_wr),
        .reg_rdata (reg_rdata)
    );

    irqc_periodic #(.CLK_PER_US(CLK_PER_US), .US_PER_UNIT(US_PER_UNIT)) u_per (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timing_wr),
        .period  (period_q),
        .per_set (per_set)
    );

    assign pending = |(cause_q & enable_q);
    assign bypass  = urgent_q && cause_q[BIT_URGENT_RX] && enable_q[BIT_URGENT_RX];

    irqc_seq #(.CLK_PER_US(CLK_PER_US), .US_PER_UNIT(US_PER_UNIT)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pending (pending),
        .bypass  (bypass),
        .holdoff (holdoff_q),
        .irq     (irq_out)
    );
endmodule

// File: rtl/irq_coalesce_ctrl_chk.sv
module irq_coalesce_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] hw_event,
    input logic        hipri_rx,
    input logic        reg_wr,
    input logic [1:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        irq_out,
    input logic [31:0] cause,
    input logic [31:0] enable
);
    assert_sticky_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_event != 32'd0) |=> ((cause & $past(hw_event)) == $past(hw_event)));

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0 && hw_event == 32'd0 && !hipri_rx)
        |=> ((cause | 32'h1000_0000) ==
             (($past(cause) & ~$past(reg_wdata)) | 32'h1000_0000)));

    assert_mask_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1 && reg_wdata == 32'd0) |=> !irq_out);

    assert_rise_needs_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|(cause & enable)));
endmodule

bind irq_coalesce_ctrl irq_coalesce_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_event  (hw_event),
    .hipri_rx  (hipri_rx),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .irq_out   (irq_out),
    .cause     (cause_q),
    .enable    (enable_q)
);

// File: tb/irq_coalesce_ctrl_test.sv
`timescale 1ns/1ps
module irq_coalesce_ctrl_test;
    localparam int CPU = 2;
    localparam int UNIT = 32 * CPU;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] hw_event = '0;
    logic        hipri_rx = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int tests = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    irq_coalesce_ctrl #(.CLK_PER_US(CPU), .US_PER_UNIT(32)) uut (
        .clk(clk), .rst_n(rst_n), .hw_event(hw_event), .hipri_rx(hipri_rx),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    // {event[96:65], write[64], wdata[63:32], expected cause[31:0]}
    localparam logic [96:0] VEC [10] = '{
        {32'h0000_0001, 1'b0, 32'h0000_0000, 32'h0000_0001},
        {32'h0800_0000, 1'b0, 32'h0000_0000, 32'h0800_0001},
        {32'h0000_0000, 1'b1, 32'h0000_0000, 32'h0800_0001},
        {32'h0000_0000, 1'b1, 32'h0000_0001, 32'h0800_0000},
        {32'h0000_0008, 1'b1, 32'h0000_0008, 32'h0800_0008},
        {32'h8000_0040, 1'b1, 32'h0800_0000, 32'h8000_0048},
        {32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000},
        {32'h2600_0082, 1'b0, 32'h0000_0000, 32'h2600_0082},
        {32'h0000_0000, 1'b1, 32'h2000_0002, 32'h0600_0080},
        {32'h0000_0000, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic ev(input logic [31:0] v);
        @(negedge clk);
        hw_event = v;
        @(negedge clk);
        hw_event = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11 reset state and map
        rd(2'd0, d); chk("R1 cause", d, 32'h0);
        rd(2'd1, d); chk("R1 enable", d, 32'h0);
        rd(2'd2, d); chk("R1 timing", d, 32'h0000_0040);
        rd(2'd3, d); chk("R11 addr3", d, 32'h0);
        chk("R1 irq", {31'b0, irq_out}, 32'h0);

        // R2 R3 R4 R5: vector table, mask 0 keeps irq low
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            reg_addr = 2'd0;
            hw_event = VEC[i][96:65];
            reg_wr = VEC[i][64];
            reg_wdata = VEC[i][63:32];
            @(negedge clk);
            hw_event = '0; reg_wr = 1'b0; reg_wdata = '0;
            rd(2'd0, d); chk("R2/R3/R4 table", d, VEC[i][31:0]);
            chk("R5 masked irq", {31'b0, irq_out}, 32'h0);
        end

        // R6 exact hold-off, N=2
        wr(2'd2, 32'h0000_0002);
        rd(2'd2, d); chk("R11 timing readback", d, 32'h0000_0002);
        wr(2'd1, 32'h0000_0001);
        ev(32'h1);
        idle(2 * UNIT);
        chk("R6 before expiry", {31'b0, irq_out}, 32'h0);
        idle(1);
        chk("R6 at expiry", {31'b0, irq_out}, 32'h1);
        wr(2'd0, 32'h1);
        chk("R5 drop on clear", {31'b0, irq_out}, 32'h0);

        // R9 rearm after mid-hold clear, N=1
        wr(2'd2, 32'h0000_0001);
        ev(32'h1);
        idle(30);
        chk("R9 holding", {31'b0, irq_out}, 32'h0);
        wr(2'd0, 32'h1);
        ev(32'h1);
        idle(UNIT);
        chk("R9 full delay not yet", {31'b0, irq_out}, 32'h0);
        idle(1);
        chk("R9 full delay fires", {31'b0, irq_out}, 32'h1);
        wr(2'd0, 32'h1);

        // R7 zero hold-off
        wr(2'd2, 32'h0);
        wr(2'd1, 32'h2);
        ev(32'h2);
        chk("R7 capture cycle", {31'b0, irq_out}, 32'h0);
        idle(1);
        chk("R7 next cycle", {31'b0, irq_out}, 32'h1);
        wr(2'd0, 32'h2);

        // R5 masked cause, then enable it
        wr(2'd1, 32'h1);
        ev(32'h8);
        idle(10);
        chk("R5 masked pending", {31'b0, irq_out}, 32'h0);
        wr(2'd1, 32'h8);
        chk("R5 enable edge", {31'b0, irq_out}, 32'h0);
        idle(1);
        chk("R5 after enable", {31'b0, irq_out}, 32'h1);
        wr(2'd0, 32'h8);
        chk("R5 cleared", {31'b0, irq_out}, 32'h0);

        // R8 urgent bypass during long hold-off
        wr(2'd2, 32'h0000_00FF);
        wr(2'd1, 32'h8000_0001);
        ev(32'h1);
        idle(5);
        chk("R8 holding", {31'b0, irq_out}, 32'h0);
        @(negedge clk); hipri_rx = 1'b1;
        @(negedge clk); hipri_rx = 1'b0;
        chk("R8 capture cycle", {31'b0, irq_out}, 32'h0);
        idle(1);
        chk("R8 bypass fires", {31'b0, irq_out}, 32'h1);
        rd(2'd0, d); chk("R8 cause bits", d, 32'h8000_0001);
        wr(2'd0, 32'hFFFF_FFFF);
        chk("R8 cleared", {31'b0, irq_out}, 32'h0);

        // R10 periodic, P=2
        wr(2'd1, 32'h0);
        wr(2'd2, 32'h0000_0200);
        idle(2 * UNIT - 1);
        rd(2'd0, d); chk("R10 before period", d, 32'h0);
        idle(1);
        rd(2'd0, d); chk("R10 first period", d, 32'h1000_0000);
        wr(2'd0, 32'h1000_0000);
        idle(2 * UNIT - 3);
        rd(2'd0, d); chk("R10 before second", d, 32'h0);
        idle(1);
        rd(2'd0, d); chk("R10 second period", d, 32'h1000_0000);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h1000_0000);
        idle(300);
        rd(2'd0, d); chk("R10 disabled", d, 32'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule